// File: doc/BRIEF.md
# DVI Frame Timing and Control-Symbol Sequencer

This block walks a 640x480 DVI raster one pixel tick at a time. At each enabled tick it moves to the next position on the screen. It reports that position and whether the position lies in the visible picture. For every position it also supplies the 10-bit control symbol that each of the three TMDS lanes (red, green, blue) sends while no pixel data is on the wire.

The link has no separate sync wires. Horizontal and vertical sync are signalled only through the choice of symbol on the blue lane. The red and green lanes always carry the plain idle symbol.

A downstream stage uses `data_en` to choose between its own encoded pixel byte and the control symbols given here. It then serialises the lanes. The position, `data_en` and all three symbols come from one register stage, so they always describe the same tick. `tick_en` lets the pixel rate be a fraction of the clock.

Top module: `dvi_frame_seq`

## Requirements
- R1: `pix_x` counts 0 to 799 and then returns to 0, giving 800 ticks per line. It moves forward by one on each clock edge at which `tick_en` is high.
- R2: `pix_y` counts 0 to 524 and then returns to 0, giving 525 lines per frame. It moves forward by one on the edge at which `pix_x` goes from 799 to 0.
- R3: `data_en` is 1 exactly when `pix_x` < 640 and `pix_y` < 480.
- R4: `sym_red` and `sym_grn` always carry the idle symbol 10'b1101010100, in blanking and in the visible area alike.
- R5: On lines outside vertical sync, during blanking, `sym_blu` is 10'b0010101011 for `pix_x` 656 to 671 (horizontal sync). At every other blanking position it is 10'b1101010100. While `data_en` is 1, `sym_blu` is 10'b1101010100.
- R6: On lines 490 and 491 (vertical sync), every blanking tick on `sym_blu` uses the vertical-sync variant: 10'b1010101011 for `pix_x` 656 to 671, and 10'b0101010100 for all other positions on those lines.
- R7: While `tick_en` is low, `pix_x`, `pix_y`, `data_en` and all three symbols keep their values.
- R8: Reset (`rst_n` low, asynchronous) shows position (0,0): `pix_x`=0, `pix_y`=0, `data_en`=1 and all lanes idle. The first enabled tick after reset shows `pix_x`=1. Symbols and `data_en` always match the position shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advance one pixel tick on this edge |
| data_en | output | 1 | Current position is inside the visible picture |
| pix_x | output | 10 | Horizontal position, 0 to 799 |
| pix_y | output | 10 | Line number, 0 to 524 |
| sym_red | output | 10 | Control symbol for the red lane |
| sym_grn | output | 10 | Control symbol for the green lane |
| sym_blu | output | 10 | Control symbol for the blue lane, carrying the sync state |

## Verification
The bench uses two instances. The default one is run over its first lines, which covers the 800-tick line, the line wrap and horizontal sync on visible lines. A reduced-geometry instance is run through many full frames, which covers the frame wrap and both vertical-sync symbol variants. The enable input is given a gapped pattern and also held solidly high. The gaps show that the position and symbols hold when the enable is low. The solid run shows back-to-back stepping. A reset in the middle of a frame shows that the raster restarts at (0,0) and that the first tick after reset goes to x=1.

// File: rtl/dvi_seq_pkg.sv
package dvi_seq_pkg;

   localparam int SYM_W = 10;
   typedef logic [SYM_W-1:0] sym_t;

   // blanking symbols, named by the sync state they carry
   localparam sym_t SYM_IDLE  = 10'b1101010100;
   localparam sym_t SYM_HS    = 10'b0010101011;
   localparam sym_t SYM_VS    = 10'b0101010100;
   localparam sym_t SYM_HS_VS = 10'b1010101011;

   function automatic sym_t blue_ctrl(input logic vs, input logic hs);
      sym_t s;
      case ({vs, hs})
         2'b01:   s = SYM_HS;
         2'b10:   s = SYM_VS;
         2'b11:   s = SYM_HS_VS;
         default: s = SYM_IDLE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/dvi_axis_ctr.sv
module dvi_axis_ctr #(
   parameter int LIMIT = 800,
   parameter int W     = $clog2(LIMIT)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic [W-1:0] nxt
);

   logic at_end;

   assign at_end = (cnt == W'(LIMIT - 1));

   always_comb begin
      if (!step)
         nxt = cnt;
      else if (at_end)
         nxt = '0;
      else
         nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else
         cnt <= nxt;
   end

endmodule

// File: rtl/dvi_sym_map.sv
module dvi_sym_map
   import dvi_seq_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int H_FRONT  = 16,
   parameter int H_SYNC   = 16,
   parameter int V_ACTIVE = 480,
   parameter int V_FRONT  = 10,
   parameter int V_SYNC   = 2,
   parameter int XW       = 10,
   parameter int YW       = 10
) (
   input  logic [XW-1:0] pos_x,
   input  logic [YW-1:0] pos_y,
   output logic          act,
   output sym_t          lane_r,
   output sym_t          lane_g,
   output sym_t          lane_b
);

   localparam int HS_BEG = H_ACTIVE + H_FRONT;
   localparam int HS_END = HS_BEG + H_SYNC;
   localparam int VS_BEG = V_ACTIVE + V_FRONT;
   localparam int VS_END = VS_BEG + V_SYNC;

   logic in_hs, in_vs;

   always_comb begin
      in_hs  = (int'(pos_x) >= HS_BEG) && (int'(pos_x) < HS_END);
      in_vs  = (int'(pos_y) >= VS_BEG) && (int'(pos_y) < VS_END);
      act    = (int'(pos_x) < H_ACTIVE) && (int'(pos_y) < V_ACTIVE);
      lane_r = SYM_IDLE;
      lane_g = SYM_IDLE;
      lane_b = act ? SYM_IDLE : blue_ctrl(in_vs, in_hs);
   end

endmodule

// File: rtl/dvi_frame_seq.sv
module dvi_frame_seq
   import dvi_seq_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int H_FRONT  = 16,
   parameter int H_SYNC   = 16,
   parameter int H_BACK   = 128,
   parameter int V_ACTIVE = 480,
   parameter int V_FRONT  = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BACK   = 33,
   localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
   localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
   localparam int XW      = $clog2(H_TOTAL),
   localparam int YW      = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   output logic          data_en,
   output logic [XW-1:0] pix_x,
   output logic [YW-1:0] pix_y,
   output logic [9:0]    sym_red,
   output logic [9:0]    sym_grn,
   output logic [9:0]    sym_blu
);

   // elaboration-time geometry checks
   if (H_ACTIVE < 1 || V_ACTIVE < 1) begin : g_bad_active
      $error("dvi_frame_seq: active area must be at least one tick and one line");
   end
   if (H_SYNC < 1 || V_SYNC < 1) begin : g_bad_sync
      $error("dvi_frame_seq: sync widths must be positive");
   end
   if (H_FRONT < 0 || H_BACK < 0 || V_FRONT < 0 || V_BACK < 0) begin : g_bad_porch
      $error("dvi_frame_seq: porches must not be negative");
   end
   if (SYM_W != 10) begin : g_bad_sym
      $error("dvi_frame_seq: lane symbols must be 10 bits");
   end

   logic          line_end;
   logic [XW-1:0] x_nxt;
   logic [YW-1:0] y_nxt;
   logic          de_nxt;
   sym_t          r_nxt, g_nxt, b_nxt;

   assign line_end = (pix_x == XW'(H_TOTAL - 1));

   dvi_axis_ctr #(.LIMIT(H_TOTAL), .W(XW)) u_hctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (tick_en),
      .cnt   (pix_x),
      .nxt   (x_nxt)
   );

   dvi_axis_ctr #(.LIMIT(V_TOTAL), .W(YW)) u_vctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (tick_en && line_end),
      .cnt   (pix_y),
      .nxt   (y_nxt)
   );

   // decode the position the counters move to, so symbols land with it
   dvi_sym_map #(
      .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC),
      .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC),
      .XW       (XW),       .YW      (YW)
   ) u_map (
      .pos_x  (x_nxt),
      .pos_y  (y_nxt),
      .act    (de_nxt),
      .lane_r (r_nxt),
      .lane_g (g_nxt),
      .lane_b (b_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_en <= 1'b1;
         sym_red <= SYM_IDLE;
         sym_grn <= SYM_IDLE;
         sym_blu <= SYM_IDLE;
      end else if (tick_en) begin
         data_en <= de_nxt;
         sym_red <= r_nxt;
         sym_grn <= g_nxt;
         sym_blu <= b_nxt;
      end
   end

endmodule

// File: rtl/dvi_frame_seq_chk.sv
module dvi_frame_seq_chk
   import dvi_seq_pkg::*;
#(
   parameter int H_ACTIVE = 640,
   parameter int H_FRONT  = 16,
   parameter int H_SYNC   = 16,
   parameter int H_BACK   = 128,
   parameter int V_ACTIVE = 480,
   parameter int V_FRONT  = 10,
   parameter int V_SYNC   = 2,
   parameter int V_BACK   = 33,
   parameter int XW       = 10,
   parameter int YW       = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic          data_en,
   input logic [XW-1:0] pix_x,
   input logic [YW-1:0] pix_y,
   input logic [9:0]    sym_red,
   input logic [9:0]    sym_grn,
   input logic [9:0]    sym_blu
);

   localparam int HT  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int VT  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int VSB = V_ACTIVE + V_FRONT;
   localparam int VSE = VSB + V_SYNC;

   assert_x_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (int'(pix_x) ==
         ((int'($past(pix_x)) == HT - 1) ? 0 : int'($past(pix_x)) + 1)));

   assert_y_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && int'(pix_x) == HT - 1) |=> (int'(pix_y) ==
         ((int'($past(pix_y)) == VT - 1) ? 0 : int'($past(pix_y)) + 1)));

   assert_de_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      data_en |-> (int'(pix_x) < H_ACTIVE && int'(pix_y) < V_ACTIVE));

   assert_rg_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_red == SYM_IDLE) && (sym_grn == SYM_IDLE));

   assert_blue_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_blu == SYM_IDLE || sym_blu == SYM_HS ||
       sym_blu == SYM_VS   || sym_blu == SYM_HS_VS));

   assert_vs_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_en && int'(pix_y) >= VSB && int'(pix_y) < VSE) |->
         (sym_blu == SYM_VS || sym_blu == SYM_HS_VS));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> ($stable(pix_x) && $stable(pix_y) &&
                    $stable(data_en) && $stable(sym_blu)));

endmodule

bind dvi_frame_seq dvi_frame_seq_chk #(
   .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK),
   .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC), .V_BACK (V_BACK),
   .XW       (XW),       .YW      (YW)
) u_chk (.*);

// File: tb/dvi_frame_seq_bench.sv
module dvi_frame_seq_bench;

   localparam logic [9:0] E_IDLE = 10'b1101010100;
   localparam logic [9:0] E_HS   = 10'b0010101011;
   localparam logic [9:0] E_VS   = 10'b0101010100;
   localparam logic [9:0] E_HV   = 10'b1010101011;

   // reduced geometry: line 16 ticks, frame 12 lines
   localparam int S_HA = 8, S_HF = 2, S_HS = 2, S_HB = 4;
   localparam int S_VA = 6, S_VF = 2, S_VS = 2, S_VB = 2;
   localparam int S_XW = $clog2(S_HA + S_HF + S_HS + S_HB);
   localparam int S_YW = $clog2(S_VA + S_VF + S_VS + S_VB);

   typedef struct {
      bit         de;
      int         x;
      int         y;
      logic [9:0] r, g, b;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;

   logic       b_de;
   logic [9:0] b_x, b_y, b_r, b_g, b_b;
   logic            s_de;
   logic [S_XW-1:0] s_x;
   logic [S_YW-1:0] s_y;
   logic [9:0]      s_r, s_g, s_b;

   int n_checks = 0;
   int n_fail = 0;
   int bx = 0, by = 0, sx = 0, sy = 0;
   item_t q_big[$];
   item_t q_sml[$];

   always #5 clk = ~clk;

   dvi_frame_seq u_dvi_frame_seq (
      .clk (clk), .rst_n (rst_n), .tick_en (en),
      .data_en (b_de), .pix_x (b_x), .pix_y (b_y),
      .sym_red (b_r), .sym_grn (b_g), .sym_blu (b_b)
   );

   dvi_frame_seq #(
      .H_ACTIVE (S_HA), .H_FRONT (S_HF), .H_SYNC (S_HS), .H_BACK (S_HB),
      .V_ACTIVE (S_VA), .V_FRONT (S_VF), .V_SYNC (S_VS), .V_BACK (S_VB)
   ) u_dvi_frame_seq_small (
      .clk (clk), .rst_n (rst_n), .tick_en (en),
      .data_en (s_de), .pix_x (s_x), .pix_y (s_y),
      .sym_red (s_r), .sym_grn (s_g), .sym_blu (s_b)
   );

   function automatic item_t model(int x, int y, int ha, int hf, int hs,
                                   int va, int vf, int vs);
      item_t it;
      bit hsy, vsy;
      it.x  = x;
      it.y  = y;
      it.de = (x < ha) && (y < va);
      it.r  = E_IDLE;
      it.g  = E_IDLE;
      hsy   = (x >= ha + hf) && (x < ha + hf + hs);
      vsy   = (y >= va + vf) && (y < va + vf + vs);
      if (it.de)            it.b = E_IDLE;
      else if (vsy && hsy)  it.b = E_HV;
      else if (vsy)         it.b = E_VS;
      else if (hsy)         it.b = E_HS;
      else                  it.b = E_IDLE;
      return it;
   endfunction

   function automatic item_t exp_big(int x, int y);
      return model(x, y, 640, 16, 16, 480, 10, 2);
   endfunction

   function automatic item_t exp_sml(int x, int y);
      return model(x, y, S_HA, S_HF, S_HS, S_VA, S_VF, S_VS);
   endfunction

   task automatic check(string who, string tag, item_t e, bit ade, int ax, int ay,
                        logic [9:0] ar, logic [9:0] ag, logic [9:0] ab);
      string t;
      n_checks++;
      if (ade !== e.de || ax != e.x || ay != e.y ||
          ar !== e.r || ag !== e.g || ab !== e.b) begin
         n_fail++;
         if (tag != "")            t = tag;
         else if (ax != e.x)       t = "R1";
         else if (ay != e.y)       t = "R2";
         else if (ade !== e.de)    t = "R3";
         else if (ar !== e.r || ag !== e.g) t = "R4";
         else if (e.b == E_VS || e.b == E_HV) t = "R6";
         else                      t = "R5";
         $display("FAIL %s %s: actual de=%0b x=%0d y=%0d r=%b g=%b b=%b expected de=%0b x=%0d y=%0d r=%b g=%b b=%b",
                  t, who, ade, ax, ay, ar, ag, ab, e.de, e.x, e.y, e.r, e.g, e.b);
      end
   endtask

   task automatic adv(inout int x, inout int y, input int ht, input int vt);
      if (x == ht - 1) begin
         x = 0;
         y = (y == vt - 1) ? 0 : y + 1;
      end else begin
         x = x + 1;
      end
   endtask

   // driver: one tick per call, pushes the position the design should show next
   task automatic drive(bit e);
      @(negedge clk);
      en = e;
      if (e) begin
         adv(bx, by, 800, 525);
         q_big.push_back(exp_big(bx, by));
         adv(sx, sy, S_HA + S_HF + S_HS + S_HB, S_VA + S_VF + S_VS + S_VB);
         q_sml.push_back(exp_sml(sx, sy));
      end
   endtask

   // R8: reset state is position (0,0), visible, all lanes idle
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      en = 1'b0;
      bx = 0; by = 0; sx = 0; sy = 0;
      q_big.delete();
      q_sml.delete();
      #1;
      check("big reset", "R8", exp_big(0, 0), b_de, int'(b_x), int'(b_y), b_r, b_g, b_b);
      check("small reset", "R8", exp_sml(0, 0), s_de, int'(s_x), int'(s_y), s_r, s_g, s_b);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // monitor: pops on enabled edges, checks holding (R7) on idle edges
   always @(posedge clk) begin
      bit e, r;
      item_t ib, is;
      e = en;
      r = rst_n;
      #2;
      if (r) begin
         if (e) begin
            if (q_big.size() == 0 || q_sml.size() == 0) begin
               n_checks++;
               n_fail++;
               $display("FAIL R1 scoreboard: actual empty queue expected item");
            end else begin
               ib = q_big.pop_front();
               is = q_sml.pop_front();
               check("big", "", ib, b_de, int'(b_x), int'(b_y), b_r, b_g, b_b);
               check("small", "", is, s_de, int'(s_x), int'(s_y), s_r, s_g, s_b);
            end
         end else begin
            check("big hold", "R7", exp_big(bx, by), b_de, int'(b_x), int'(b_y), b_r, b_g, b_b);
            check("small hold", "R7", exp_sml(sx, sy), s_de, int'(s_x), int'(s_y), s_r, s_g, s_b);
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      do_reset();
      // first tick after reset lands on x=1 (R8); gapped enable covers R7
      for (int i = 0; i < 2000; i++)
         drive(((i % 7) != 3) && ((i % 13) != 5));
      drive(1'b0);
      // mid-frame reset, then solid enable across many small frames (R2, R6)
      do_reset();
      for (int i = 0; i < 2200; i++)
         drive(1'b1);
      drive(1'b0);
      drive(1'b0);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule